// File: doc/BRIEF.md
# Time-Triggered Transmit Mailbox Scheduler

This block decides, for a set of time-triggered transmit mailboxes, the moment at which each one may ask the bus arbitration stage to send. Each mailbox holds a 16-bit trigger time, a base-cycle offset, a repeat period given as a power of two, a 2-bit window code and a 3-bit configuration field. The block runs its own cycle-time counter and basic-cycle counter. When a pending mailbox's trigger time equals the cycle time and its offset agrees with the basic-cycle count modulo its period, the mailbox is armed. A three-state machine (idle, requesting, transferring) offers the lowest-numbered armed mailbox to the arbitration stage through a request/grant/done/abort handshake.

Pending bits stay set after a successful send, so the send repeats in every matching basic cycle until the host cancels it. Cancel, acknowledge and abort-acknowledge flags are kept per mailbox. A cancel that arrives while the mailbox is on the bus waits until the transfer ends. If the acknowledge flag has not been cleared by then, both acknowledge and abort-acknowledge end up set for that mailbox. The block also keeps track of whether a merged arbitrating window is open, based on the window codes of the mailboxes it has granted.

State machine: `S_IDLE` (nothing offered), `S_REQ` (request raised for the selected mailbox), `S_XFER` (granted, waiting for the end of the transfer). Transitions: `S_IDLE -> S_REQ` when any mailbox is armed; `S_REQ -> S_XFER` on grant; `S_REQ -> S_IDLE` (withdraw) when the selected mailbox is disarmed by a cancel; `S_XFER -> S_IDLE` on done or abort. The machine otherwise stays in its current state.

Top module: `tt_tx_sched`

## Requirements
- R1: After reset, `tx_req`, `pend`, `ack`, `abt` and `merged_open` are all 0, and both `cycle_time` and `cycle_count` are 0.
- R2: While `timer_run` is 1, `cycle_time` advances by one each clock. After it reaches `cyc_last` it returns to 0 and `cycle_count` advances. `cycle_count` returns to 0 after it reaches `cyc_max`. While `timer_run` is 0, both counters are cleared.
- R3: No mailbox is armed or requested while `timer_run` is 0 or `cyc_max` equals 3'b111.
- R4: A mailbox is armed when all of the following hold: its pending bit is set, its configuration field is 3'b000, its trigger time equals `cycle_time`, and `cycle_count` modulo 2^plog equals its offset (plog is its 2-bit period field). The request is visible with `cycle_time` two ticks past the trigger time.
- R5: When several mailboxes are armed, the lowest-numbered one is requested first. The others are requested after it completes.
- R6: `tx_req` and `tx_mb` stay steady until `tx_grant` is seen. After a grant, the block waits for `tx_done` or `tx_abort`.
- R7: `tx_done` sets the mailbox's acknowledge flag and leaves its pending bit set, so the mailbox is requested again in the next matching basic cycle.
- R8: `tx_abort` drops the current attempt without setting the acknowledge flag, and leaves the pending bit set.
- R9: A cancel to a pending mailbox that is not on the bus clears its pending bit and sets its abort-acknowledge flag, leaving the acknowledge flag as it was. A cancel to a mailbox that is not pending has no effect.
- R10: A cancel that arrives after the grant keeps the pending bit set until done or abort. At that point the pending bit clears and abort-acknowledge is set, together with acknowledge on done.
- R11: A 1 on `ack_clr[i]` or `abt_clr[i]` clears the matching flag. A flag being set in the same cycle takes priority over the clear.
- R12: `tx_win` gives the window code of the requested mailbox (00 exclusive, 01 arbitrating, 10 merged start, 11 merged end). A grant with code 10 sets `merged_open`, a grant with 11 clears it, and codes 00 and 01 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_run | input | 1 | Cycle timer run enable |
| cyc_max | input | CNT_W | Last basic-cycle count; all ones disables triggering |
| cyc_last | input | TIME_W | Last cycle-time value of a basic cycle |
| mb_ttime | input | NUM_MB*TIME_W | Trigger time per mailbox |
| mb_offset | input | NUM_MB*CNT_W | Base-cycle offset per mailbox |
| mb_plog | input | NUM_MB*PER_W | Log2 of repeat period per mailbox |
| mb_win | input | NUM_MB*2 | Window code per mailbox |
| mb_cfg | input | NUM_MB*3 | Configuration field per mailbox (000 = time-triggered transmit) |
| pend_set | input | NUM_MB | Host sets pending bit |
| cancel_set | input | NUM_MB | Host cancel request |
| ack_clr | input | NUM_MB | Write-one-to-clear for acknowledge flags |
| abt_clr | input | NUM_MB | Write-one-to-clear for abort-acknowledge flags |
| tx_req | output | 1 | Transmit request to arbitration |
| tx_mb | output | IDX_W | Index of requested mailbox |
| tx_win | output | 2 | Window code of requested mailbox |
| tx_grant | input | 1 | Arbitration grant |
| tx_done | input | 1 | Transfer completed successfully |
| tx_abort | input | 1 | Transfer abandoned |
| pend | output | NUM_MB | Pending bits |
| ack | output | NUM_MB | Acknowledge flags |
| abt | output | NUM_MB | Abort-acknowledge flags |
| merged_open | output | 1 | Merged arbitrating window is open |
| cycle_time | output | TIME_W | Cycle-time counter |
| cycle_count | output | CNT_W | Basic-cycle counter |

## Verification
The hardest case to reach is a cancel that lands after the grant but before the end of the transfer. In that case the pending bit must survive for a while and then clear together with both flags. The stimulus waits for the request, drives the grant, and in the following cycle pulses the cancel while the transfer is still open. It checks the pending bit, then ends the transfer with done. The offset case needs some care as well: a period-two mailbox with offset one may only be requested in odd basic cycles, so the bench follows two successive requests across the count.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_REQ  = 2'b01,
        S_XFER = 2'b10
    } fsm_t;

    typedef enum logic [1:0] {
        WIN_EXCL   = 2'b00,
        WIN_ARB    = 2'b01,
        WIN_MSTART = 2'b10,
        WIN_MEND   = 2'b11
    } win_t;

endpackage

// File: rtl/tt_cycle_timer.sv
module tt_cycle_timer #(
    parameter int TIME_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TIME_W-1:0] cyc_last,
    input  logic [CNT_W-1:0]  cyc_max,
    output logic [TIME_W-1:0] ct,
    output logic [CNT_W-1:0]  cc
);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ct <= '0;
            cc <= '0;
        end else if (ct == cyc_last) begin
            ct <= '0;
            cc <= (cc >= cyc_max) ? '0 : cc + 1'b1;
        end else begin
            ct <= ct + 1'b1;
        end
    end

    // R2: a stopped timer reads zero on the next tick
    a_r2_run_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ct == '0 && cc == '0));

endmodule

// File: rtl/tt_mb_match.sv
module tt_mb_match #(
    parameter int NUM_MB = 4,
    parameter int TIME_W = 16,
    parameter int CNT_W  = 3,
    parameter int PER_W  = 2
) (
    input  logic                     tt_en,
    input  logic [TIME_W-1:0]        ct,
    input  logic [CNT_W-1:0]         cc,
    input  logic [NUM_MB*TIME_W-1:0] mb_ttime,
    input  logic [NUM_MB*CNT_W-1:0]  mb_offset,
    input  logic [NUM_MB*PER_W-1:0]  mb_plog,
    input  logic [NUM_MB*3-1:0]      mb_cfg,
    input  logic [NUM_MB-1:0]        pend,
    output logic [NUM_MB-1:0]        hit
);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic [CNT_W-1:0] mask;
        logic             time_eq;
        logic             base_eq;
        logic             cfg_ok;

        always_comb begin
            mask    = ~({CNT_W{1'b1}} << mb_plog[g*PER_W +: PER_W]);
            time_eq = (mb_ttime[g*TIME_W +: TIME_W] == ct);
            base_eq = ((cc & mask) == mb_offset[g*CNT_W +: CNT_W]);
            cfg_ok  = (mb_cfg[g*3 +: 3] == 3'b000);
            hit[g]  = tt_en & pend[g] & cfg_ok & time_eq & base_eq;
        end
    end

endmodule

// File: rtl/tt_tx_fsm.sv
module tt_tx_fsm
    import tt_sched_pkg::*;
#(
    parameter int NUM_MB = 4,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_MB-1:0] armed,
    input  logic              tx_grant,
    input  logic              tx_done,
    input  logic              tx_abort,
    output fsm_t              state,
    output logic [IDX_W-1:0]  cur,
    output logic              tx_req
);

    fsm_t             nxt;
    logic [IDX_W-1:0] pick;
    logic             any;

    always_comb begin
        pick = '0;
        any  = |armed;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (armed[i]) pick = IDX_W'(i);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (any) nxt = S_REQ;
            S_REQ: begin
                if (!armed[cur])   nxt = S_IDLE;
                else if (tx_grant) nxt = S_XFER;
            end
            S_XFER: if (tx_done || tx_abort) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cur   <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && any) cur <= pick;
        end
    end

    always_comb begin
        tx_req = (state == S_REQ);
    end

    // R6: an unanswered request keeps its mailbox
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REQ && !tx_grant && armed[cur]) |=> (state == S_REQ && $stable(cur)));

    // R5: the selected mailbox is the lowest armed one
    a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && armed[0]) |=> (cur == '0));

endmodule

// File: rtl/tt_tx_sched.sv
module tt_tx_sched
    import tt_sched_pkg::*;
#(
    parameter int NUM_MB = 4,
    parameter int TIME_W = 16,
    parameter int CNT_W  = 3,
    parameter int PER_W  = 2,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     timer_run,
    input  logic [CNT_W-1:0]         cyc_max,
    input  logic [TIME_W-1:0]        cyc_last,
    input  logic [NUM_MB*TIME_W-1:0] mb_ttime,
    input  logic [NUM_MB*CNT_W-1:0]  mb_offset,
    input  logic [NUM_MB*PER_W-1:0]  mb_plog,
    input  logic [NUM_MB*2-1:0]      mb_win,
    input  logic [NUM_MB*3-1:0]      mb_cfg,
    input  logic [NUM_MB-1:0]        pend_set,
    input  logic [NUM_MB-1:0]        cancel_set,
    input  logic [NUM_MB-1:0]        ack_clr,
    input  logic [NUM_MB-1:0]        abt_clr,
    output logic                     tx_req,
    output logic [IDX_W-1:0]         tx_mb,
    output logic [1:0]               tx_win,
    input  logic                     tx_grant,
    input  logic                     tx_done,
    input  logic                     tx_abort,
    output logic [NUM_MB-1:0]        pend,
    output logic [NUM_MB-1:0]        ack,
    output logic [NUM_MB-1:0]        abt,
    output logic                     merged_open,
    output logic [TIME_W-1:0]        cycle_time,
    output logic [CNT_W-1:0]         cycle_count
);

    fsm_t              st;
    logic [IDX_W-1:0]  cur;
    logic              tt_en;
    logic [NUM_MB-1:0] hit;
    logic [NUM_MB-1:0] armed, armed_n;
    logic [NUM_MB-1:0] defer, defer_n;
    logic [NUM_MB-1:0] pend_n, ack_n, abt_n;
    logic [NUM_MB-1:0] on_bus;
    logic              end_xfer;
    logic              grant_now;

    assign tt_en = timer_run && (cyc_max != {CNT_W{1'b1}});

    tt_cycle_timer #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_run),
        .cyc_last(cyc_last), .cyc_max(cyc_max),
        .ct(cycle_time), .cc(cycle_count)
    );

    tt_mb_match #(.NUM_MB(NUM_MB), .TIME_W(TIME_W), .CNT_W(CNT_W), .PER_W(PER_W)) u_match (
        .tt_en(tt_en), .ct(cycle_time), .cc(cycle_count),
        .mb_ttime(mb_ttime), .mb_offset(mb_offset), .mb_plog(mb_plog),
        .mb_cfg(mb_cfg), .pend(pend), .hit(hit)
    );

    tt_tx_fsm #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .tx_grant(tx_grant), .tx_done(tx_done), .tx_abort(tx_abort),
        .state(st), .cur(cur), .tx_req(tx_req)
    );

    assign tx_mb     = cur;
    assign tx_win    = mb_win[cur*2 +: 2];
    assign grant_now = (st == S_REQ) && tx_grant && armed[cur];
    assign end_xfer  = (st == S_XFER) && (tx_done || tx_abort);

    always_comb begin
        on_bus = '0;
        if (st == S_XFER || grant_now) on_bus[cur] = 1'b1;
    end

    always_comb begin
        pend_n  = pend;
        armed_n = armed;
        ack_n   = ack & ~ack_clr;
        abt_n   = abt & ~abt_clr;
        defer_n = defer;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend_set[i]) pend_n[i] = 1'b1;
            if (hit[i])      armed_n[i] = 1'b1;
            if (cancel_set[i] && pend[i]) begin
                if (on_bus[i]) begin
                    defer_n[i] = 1'b1;
                end else begin
                    pend_n[i]  = 1'b0;
                    armed_n[i] = 1'b0;
                    abt_n[i]   = 1'b1;
                end
            end
            if (end_xfer && cur == IDX_W'(i)) begin
                armed_n[i] = 1'b0;
                if (tx_done) ack_n[i] = 1'b1;
                if (defer[i] || (cancel_set[i] && pend[i])) begin
                    pend_n[i]  = 1'b0;
                    abt_n[i]   = 1'b1;
                    defer_n[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            armed <= '0;
            ack   <= '0;
            abt   <= '0;
            defer <= '0;
        end else begin
            pend  <= pend_n;
            armed <= armed_n;
            ack   <= ack_n;
            abt   <= abt_n;
            defer <= defer_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merged_open <= 1'b0;
        end else if (grant_now) begin
            if (tx_win == WIN_MSTART)    merged_open <= 1'b1;
            else if (tx_win == WIN_MEND) merged_open <= 1'b0;
        end
    end

    // R3: nothing becomes armed while triggering is off
    a_r3_no_arm_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!tt_en && armed == '0) |=> (armed == '0));

    // R7: success sets the acknowledge flag
    a_r7_ack_set: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && tx_done) |=> ack[cur]);

    // R7: success without a cancel keeps the mailbox pending
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && tx_done && !defer[cur] && !cancel_set[cur]) |=> pend[cur]);

    // R8: abort alone never acknowledges
    a_r8_no_ack_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && tx_abort && !tx_done && !ack[cur]) |=> !ack[cur]);

    // R10: a deferred cancel leaves the pending bit up during transfer
    a_r10_defer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && !tx_done && !tx_abort && defer[cur]) |=> pend[cur]);

    // R12: an end-of-merge grant closes the window
    a_r12_close: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_now && tx_win == WIN_MEND) |=> !merged_open);

endmodule

// File: tb/tt_tx_sched_bench.sv
module tt_tx_sched_bench;

    localparam int N  = 4;
    localparam int TW = 16;
    localparam int CW = 3;
    localparam int PW = 2;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            timer_run;
    logic [CW-1:0]   cyc_max;
    logic [TW-1:0]   cyc_last;
    logic [N*TW-1:0] mb_ttime;
    logic [N*CW-1:0] mb_offset;
    logic [N*PW-1:0] mb_plog;
    logic [N*2-1:0]  mb_win;
    logic [N*3-1:0]  mb_cfg;
    logic [N-1:0]    pend_set, cancel_set, ack_clr, abt_clr;
    logic            tx_req;
    logic [IW-1:0]   tx_mb;
    logic [1:0]      tx_win;
    logic            tx_grant, tx_done, tx_abort;
    logic [N-1:0]    pend, ack, abt;
    logic            merged_open;
    logic [TW-1:0]   cycle_time;
    logic [CW-1:0]   cycle_count;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tt_tx_sched #(.NUM_MB(N), .TIME_W(TW), .CNT_W(CW), .PER_W(PW)) u_tt_tx_sched (
        .clk(clk), .rst_n(rst_n), .timer_run(timer_run), .cyc_max(cyc_max),
        .cyc_last(cyc_last), .mb_ttime(mb_ttime), .mb_offset(mb_offset),
        .mb_plog(mb_plog), .mb_win(mb_win), .mb_cfg(mb_cfg),
        .pend_set(pend_set), .cancel_set(cancel_set), .ack_clr(ack_clr),
        .abt_clr(abt_clr), .tx_req(tx_req), .tx_mb(tx_mb), .tx_win(tx_win),
        .tx_grant(tx_grant), .tx_done(tx_done), .tx_abort(tx_abort),
        .pend(pend), .ack(ack), .abt(abt), .merged_open(merged_open),
        .cycle_time(cycle_time), .cycle_count(cycle_count)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_mb(input int i, input int tt, input int off, input int plog,
                          input int win, input int cfg);
        mb_ttime[i*TW +: TW]  = TW'(tt);
        mb_offset[i*CW +: CW] = CW'(off);
        mb_plog[i*PW +: PW]   = PW'(plog);
        mb_win[i*2 +: 2]      = 2'(win);
        mb_cfg[i*3 +: 3]      = 3'(cfg);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; timer_run = 1'b0; cyc_max = 3'd3; cyc_last = 16'd15;
        mb_ttime = '0; mb_offset = '0; mb_plog = '0; mb_win = '0;
        mb_cfg = {N{3'b111}};
        pend_set = '0; cancel_set = '0; ack_clr = '0; abt_clr = '0;
        tx_grant = 1'b0; tx_done = 1'b0; tx_abort = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic set_pend(input logic [N-1:0] m);
        pend_set = m; tick(); pend_set = '0;
    endtask

    task automatic wait_req(input int maxc, output bit got);
        got = 0;
        for (int k = 0; k < maxc; k++) begin
            if (tx_req) begin got = 1; break; end
            tick();
        end
    endtask

    task automatic serve();
        tx_grant = 1'b1; tick(); tx_grant = 1'b0;
        tx_done = 1'b1; tick(); tx_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tx_req", tx_req, 0);
        chk("R1 pend", pend, 0);
        chk("R1 ack", ack, 0);
        chk("R1 abt", abt, 0);
        chk("R1 merged", merged_open, 0);
        chk("R1 ctime", cycle_time, 0);
        chk("R1 ccount", cycle_count, 0);
    endtask

    task automatic t_timer();
        do_reset();
        timer_run = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        chk("R2 ctime step", cycle_time, 5);
        for (int k = 0; k < 11; k++) tick();
        chk("R2 ctime wrap", cycle_time, 0);
        chk("R2 ccount step", cycle_count, 1);
        for (int k = 0; k < 48; k++) tick();
        chk("R2 ccount wrap", cycle_count, 0);
        for (int k = 0; k < 3; k++) tick();
        timer_run = 1'b0;
        tick();
        chk("R2 stop clears", cycle_time, 0);
    endtask

    task automatic t_basic();
        bit got;
        do_reset();
        cfg_mb(0, 5, 0, 0, 0, 0);
        cfg_mb(1, 5, 0, 0, 0, 1);
        set_pend(4'b0011);
        timer_run = 1'b1;
        wait_req(40, got);
        chk("R4 req seen", got, 1);
        chk("R4 mb", tx_mb, 0);
        chk("R4 req time", cycle_time, 7);
        serve();
        chk("R7 ack", ack[0], 1);
        chk("R7 pend kept", pend[0], 1);
        wait_req(40, got);
        chk("R7 repeat", got, 1);
        chk("R7 repeat mb", tx_mb, 0);
        chk("R7 repeat cycle", cycle_count, 1);
        serve();
        chk("R4 cfg nonzero never sent", ack[1], 0);
    endtask

    task automatic t_prio();
        bit got;
        do_reset();
        cfg_mb(2, 9, 0, 0, 1, 0);
        cfg_mb(3, 9, 0, 0, 0, 0);
        set_pend(4'b1100);
        timer_run = 1'b1;
        wait_req(40, got);
        chk("R5 first", tx_mb, 2);
        tick(); tick(); tick();
        chk("R6 req held", tx_req, 1);
        chk("R6 mb held", tx_mb, 2);
        chk("R12 tx_win", tx_win, 1);
        serve();
        wait_req(4, got);
        chk("R5 second req", got, 1);
        chk("R5 second", tx_mb, 3);
        serve();
    endtask

    task automatic t_offset();
        bit got;
        do_reset();
        cfg_mb(1, 3, 1, 1, 0, 0);
        set_pend(4'b0010);
        timer_run = 1'b1;
        wait_req(100, got);
        chk("R4 offset cycle", cycle_count, 1);
        chk("R4 offset time", cycle_time, 5);
        serve();
        wait_req(100, got);
        chk("R4 offset next", cycle_count, 3);
        serve();
    endtask

    task automatic t_gate();
        int seen = 0;
        do_reset();
        cfg_mb(0, 2, 0, 0, 0, 0);
        set_pend(4'b0001);
        cyc_max = 3'b111;
        timer_run = 1'b1;
        for (int k = 0; k < 50; k++) begin tick(); if (tx_req) seen++; end
        chk("R3 cycmax off", seen, 0);
        cyc_max = 3'd3; timer_run = 1'b0;
        for (int k = 0; k < 50; k++) begin tick(); if (tx_req) seen++; end
        chk("R3 timer stopped", seen, 0);
    endtask

    task automatic t_cancel();
        bit got;
        int seen = 0;
        do_reset();
        cfg_mb(0, 4, 0, 0, 0, 0);
        set_pend(4'b0001);
        timer_run = 1'b1;
        wait_req(40, got);
        serve();
        cancel_set = 4'b0001; tick(); cancel_set = '0;
        chk("R9 pend cleared", pend[0], 0);
        chk("R9 abt set", abt[0], 1);
        chk("R9 ack kept", ack[0], 1);
        cancel_set = 4'b0010; tick(); cancel_set = '0;
        chk("R9 idle cancel ignored", abt[1], 0);
        for (int k = 0; k < 40; k++) begin tick(); if (tx_req) seen++; end
        chk("R9 no more sends", seen, 0);
        ack_clr = 4'b0001; abt_clr = 4'b0001; tick();
        ack_clr = '0; abt_clr = '0;
        chk("R11 ack clr", ack[0], 0);
        chk("R11 abt clr", abt[0], 0);
    endtask

    task automatic t_defer();
        bit got;
        do_reset();
        cfg_mb(0, 4, 0, 0, 0, 0);
        set_pend(4'b0001);
        timer_run = 1'b1;
        wait_req(40, got);
        tx_grant = 1'b1; tick(); tx_grant = 1'b0;
        cancel_set = 4'b0001; tick(); cancel_set = '0;
        chk("R10 pend held", pend[0], 1);
        chk("R10 abt not yet", abt[0], 0);
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        chk("R10 pend cleared", pend[0], 0);
        chk("R10 ack", ack[0], 1);
        chk("R10 abt", abt[0], 1);
    endtask

    task automatic t_abort();
        bit got;
        do_reset();
        cfg_mb(0, 4, 0, 0, 0, 0);
        set_pend(4'b0001);
        timer_run = 1'b1;
        wait_req(40, got);
        tx_grant = 1'b1; tick(); tx_grant = 1'b0;
        tx_abort = 1'b1; tick(); tx_abort = 1'b0;
        chk("R8 no ack", ack[0], 0);
        chk("R8 pend kept", pend[0], 1);
        chk("R8 req dropped", tx_req, 0);
        wait_req(40, got);
        chk("R8 retry cycle", cycle_count, 1);
        serve();
    endtask

    task automatic t_window();
        bit got;
        do_reset();
        cfg_mb(0, 3, 0, 0, 2, 0);
        cfg_mb(1, 6, 0, 0, 2, 0);
        cfg_mb(2, 9, 0, 0, 1, 0);
        cfg_mb(3, 12, 0, 0, 3, 0);
        set_pend(4'b1111);
        timer_run = 1'b1;
        wait_req(40, got);
        chk("R12 win start code", tx_win, 2);
        serve();
        chk("R12 opened", merged_open, 1);
        wait_req(40, got);
        chk("R12 second start mb", tx_mb, 1);
        serve();
        chk("R12 still open", merged_open, 1);
        wait_req(40, got);
        serve();
        chk("R12 arb keeps open", merged_open, 1);
        wait_req(40, got);
        chk("R12 end code", tx_win, 3);
        serve();
        chk("R12 closed", merged_open, 0);
    endtask

    initial begin
        for (int k = 0; k < 150000; k++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_timer();
        t_basic();
        t_prio();
        t_offset();
        t_gate();
        t_cancel();
        t_defer();
        t_abort();
        t_window();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule